// File: doc/BRIEF.md
# Four-Port Eight-Bank Memory Crossbar

This block connects four memory ports to eight word-interleaved data banks. Every port may reach every bank. No port presents an address with its access. Each port owns an internal address register, which software-visible control writes one or more cycles ahead. The access itself only says whether it happens, whether it stores, and how wide it is. When the ports that take part all land on different banks, the whole group completes in the cycle it is presented. When two or more land on one bank, the block raises `stall`. It then serves the group over the smallest number of cycles, which is the largest number of ports aimed at any single bank.

Requests form one group and use valid/ready handshaking. `req_valid` marks the ports that take part this cycle; a port whose operation is not on the taken path is left low. `req_ready` is the inverse of `stall`. While `req_ready` is low, the source holds every request field and every address-register write stable. The group is retired on the first edge where `req_ready` is high. Load results carry no back-pressure: `ld_valid` pulses in the cycle a port is served, and the consumer must take `ld_data` then.

Banks are read asynchronously through `bank_raddr`/`bank_rdata`. A served store is parked for one cycle in a per-bank write buffer. It is written to the bank on the following cycle with byte enables. A load that hits a parked store sees the buffered bytes merged over the bank word.

Top module: `mem_xbar4x8`

## Requirements
- R1: A write to a port's address register takes effect on the next clock edge. A request presented in the same cycle as that write uses the old address.
- R2: A port's bank is address bits [4:2] and its word index within the bank is bits [AW-1:5]. The bank a load uses drives `bank_re` high and `bank_raddr` with that word index in the cycle the load is served.
- R3: If no two requesting ports share a bank, every requesting port is served in that same cycle, with `stall` low and `req_ready` high.
- R4: If ports share a bank, `stall` stays high until the last port of the group has been served. The group takes exactly as many cycles as the largest number of ports aimed at one bank.
- R5: Among pending ports aimed at one bank, the lowest-numbered port is served first. Each port is served exactly once per group.
- R6: Address-register writes presented while `stall` is high are ignored. A write still presented in the final cycle of the group is taken at that group's last edge.
- R7: Ports with `req_valid` low take no part in conflict detection and are never served.
- R8: Load width uses size code 0 for byte, 1 for halfword, and 2 or 3 for word. A byte load returns the byte at offset bits [1:0], zero-extended. A halfword load returns bytes {2·bit1+1, 2·bit1}, zero-extended. A word load returns the whole word.
- R9: A store served in cycle n drives `bank_we`, `bank_waddr` and `bank_wbe` for its bank in cycle n+1. Byte lane i of `bank_wdata` holds the store data for the lanes selected by R8's offset rules, with enables 0001<<off for a byte, 0011<<(2·bit1) for a halfword, and 1111 for a word.
- R10: A load served in the cycle right after a store to the same bank word returns the stored bytes merged over the bank word.
- R11: `ld_valid` is high for a port only in the cycle that port is served with a load, and never for stores.
- R12: After reset, all address registers hold zero, `stall` and `bank_we` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mar_wr | input | NPORT | Per-port address-register write enable |
| mar_wdata | input | NPORT*AW | Per-port new byte address |
| req_valid | input | NPORT | Port takes part in this access group |
| req_store | input | NPORT | 1 = store, 0 = load |
| req_size | input | NPORT*2 | Access width code per port |
| req_wdata | input | NPORT*32 | Store data, low-aligned |
| req_ready | output | 1 | Group retires at this edge |
| stall | output | 1 | Bank conflict still being served |
| ld_valid | output | NPORT | Load result present this cycle |
| ld_data | output | NPORT*32 | Aligned, zero-extended load data |
| bank_re | output | NBANK | Bank read strobe |
| bank_raddr | output | NBANK*IDXW | Word index read in each bank |
| bank_rdata | input | NBANK*32 | Asynchronous read data from each bank |
| bank_we | output | NBANK | Buffered store write strobe |
| bank_waddr | output | NBANK*IDXW | Word index written |
| bank_wdata | output | NBANK*32 | Write data in byte lanes |
| bank_wbe | output | NBANK*4 | Byte write enables |

## Verification
Each served port's `stall`, `req_ready`, `ld_valid`, `ld_data`, `bank_re` and `bank_raddr` are due in the same cycle the request is held. That holds even mid-conflict, because they are combinational from the held request and the registered addresses. Buffered bank writes are due exactly one cycle after the store is served. An address-register write becomes visible to the request presented after the edge that takes it. The bench drives just after the falling edge. It compares a behavioural model against every output one nanosecond before the rising edge, and advances its model at that edge, so each result is checked in the cycle it is due.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORDX = 2'd3
  } acc_size_e;

  // effective byte offset of an access after width alignment
  function automatic logic [1:0] lane_offset(logic [1:0] off, logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return off;
      SZ_HALF: return {off[1], 1'b0};
      default: return 2'b00;
    endcase
  endfunction

  // rotate the bank word down to the access offset and zero-extend
  function automatic logic [WORD_W-1:0] load_align(logic [WORD_W-1:0] w,
                                                   logic [1:0] off, logic [1:0] sz);
    logic [4:0]        sh;
    logic [WORD_W-1:0] r;
    sh = {lane_offset(off, sz), 3'b000};
    r  = (w >> sh) | (w << (6'd32 - {1'b0, sh}));
    case (acc_size_e'(sz))
      SZ_BYTE: return {24'h0, r[7:0]};
      SZ_HALF: return {16'h0, r[15:0]};
      default: return r;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] store_lanes(logic [WORD_W-1:0] d,
                                                    logic [1:0] off, logic [1:0] sz);
    logic [4:0] sh;
    sh = {lane_offset(off, sz), 3'b000};
    return d << sh;
  endfunction

  function automatic logic [LANES-1:0] store_be(logic [1:0] off, logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return 4'b0001 << off;
      SZ_HALF: return 4'b0011 << lane_offset(off, sz);
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/xbar_mar_file.sv
module xbar_mar_file #(
  parameter int NPORT = 4,
  parameter int AW    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [NPORT-1:0]  wr_en,
  input  logic [NPORT*AW-1:0] wr_addr,
  output logic [NPORT*AW-1:0] mar_q
);
  for (genvar p = 0; p < NPORT; p++) begin : g_mar
    always_ff @(posedge clk) begin
      if (rst)
        mar_q[p*AW +: AW] <= '0;
      else if (wr_en[p] && !hold)
        mar_q[p*AW +: AW] <= wr_addr[p*AW +: AW];
    end
  end
endmodule

// File: rtl/xbar_bank_arb.sv
module xbar_bank_arb #(
  parameter  int NPORT = 4,
  parameter  int NBANK = 8,
  localparam int BSW   = $clog2(NBANK)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPORT-1:0]       req_valid,
  input  logic [NPORT*BSW-1:0]   port_bank,
  output logic [NPORT-1:0]       grant,
  output logic [NBANK*NPORT-1:0] gnt_pb,
  output logic                   stall
);
  logic [NPORT-1:0] done_q;
  logic [NPORT-1:0] pend;
  logic [NBANK-1:0] taken;
  logic [BSW-1:0]   bk;

  // lowest pending port wins each bank
  always_comb begin
    pend   = req_valid & ~done_q;
    taken  = '0;
    gnt_pb = '0;
    grant  = '0;
    bk     = '0;
    for (int p = 0; p < NPORT; p++) begin
      bk = port_bank[p*BSW +: BSW];
      if (pend[p] && !taken[bk]) begin
        taken[bk]                   = 1'b1;
        grant[p]                    = 1'b1;
        gnt_pb[int'(bk)*NPORT + p]  = 1'b1;
      end
    end
    stall = |(pend & ~grant);
  end

  always_ff @(posedge clk) begin
    if (rst)        done_q <= '0;
    else if (stall) done_q <= done_q | grant;
    else            done_q <= '0;
  end
endmodule

// File: rtl/xbar_store_buf.sv
module xbar_store_buf #(
  parameter int NBANK = 8,
  parameter int IDXW  = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NBANK-1:0]      st_fire,
  input  logic [NBANK*IDXW-1:0] st_idx,
  input  logic [NBANK*32-1:0]   st_data,
  input  logic [NBANK*4-1:0]    st_be,
  input  logic [NBANK*IDXW-1:0] rd_idx,
  input  logic [NBANK*32-1:0]   rd_data,
  output logic [NBANK*32-1:0]   merged,
  output logic [NBANK-1:0]      wb_en,
  output logic [NBANK*IDXW-1:0] wb_idx,
  output logic [NBANK*32-1:0]   wb_data,
  output logic [NBANK*4-1:0]    wb_be
);
  for (genvar b = 0; b < NBANK; b++) begin : g_ent
    logic            v_q;
    logic [IDXW-1:0] idx_q;
    logic [31:0]     dat_q;
    logic [3:0]      be_q;
    logic            hit;

    always_ff @(posedge clk) begin
      if (rst) v_q <= 1'b0;
      else     v_q <= st_fire[b];
    end

    always_ff @(posedge clk) begin
      if (st_fire[b]) begin
        idx_q <= st_idx[b*IDXW +: IDXW];
        dat_q <= st_data[b*32 +: 32];
        be_q  <= st_be[b*4 +: 4];
      end
    end

    assign hit = v_q && (idx_q == rd_idx[b*IDXW +: IDXW]);

    for (genvar i = 0; i < 4; i++) begin : g_lane
      assign merged[b*32 + i*8 +: 8] = (hit && be_q[i]) ? dat_q[i*8 +: 8]
                                                        : rd_data[b*32 + i*8 +: 8];
    end

    assign wb_en[b]                = v_q;
    assign wb_idx[b*IDXW +: IDXW]  = idx_q;
    assign wb_data[b*32 +: 32]     = dat_q;
    assign wb_be[b*4 +: 4]         = be_q;
  end
endmodule

// File: rtl/mem_xbar4x8.sv
module mem_xbar4x8
  import xbar_pkg::*;
#(
  parameter  int NPORT = 4,
  parameter  int NBANK = 8,
  parameter  int AW    = 12,
  localparam int BSW   = $clog2(NBANK),
  localparam int IDXW  = AW - 2 - BSW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPORT-1:0]      mar_wr,
  input  logic [NPORT*AW-1:0]   mar_wdata,
  input  logic [NPORT-1:0]      req_valid,
  input  logic [NPORT-1:0]      req_store,
  input  logic [NPORT*2-1:0]    req_size,
  input  logic [NPORT*32-1:0]   req_wdata,
  output logic                  req_ready,
  output logic                  stall,
  output logic [NPORT-1:0]      ld_valid,
  output logic [NPORT*32-1:0]   ld_data,
  output logic [NBANK-1:0]      bank_re,
  output logic [NBANK*IDXW-1:0] bank_raddr,
  input  logic [NBANK*32-1:0]   bank_rdata,
  output logic [NBANK-1:0]      bank_we,
  output logic [NBANK*IDXW-1:0] bank_waddr,
  output logic [NBANK*32-1:0]   bank_wdata,
  output logic [NBANK*4-1:0]    bank_wbe
);
  logic [NPORT*AW-1:0]   mar_q;
  logic [NPORT*BSW-1:0]  port_bank;
  logic [NPORT*IDXW-1:0] port_idx;
  logic [NPORT*2-1:0]    port_off;
  logic [NPORT-1:0]      grant;
  logic [NBANK*NPORT-1:0] gnt_pb;
  logic [NBANK-1:0]      st_fire;
  logic [NBANK*IDXW-1:0] st_idx;
  logic [NBANK*32-1:0]   st_data;
  logic [NBANK*4-1:0]    st_be;
  logic [NBANK*32-1:0]   merged;
  logic [31:0]           merged_arr [NBANK];

  xbar_mar_file #(.NPORT(NPORT), .AW(AW)) u_mar (
    .clk(clk), .rst(rst), .hold(stall),
    .wr_en(mar_wr), .wr_addr(mar_wdata), .mar_q(mar_q)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign port_off[p*2 +: 2]       = mar_q[p*AW +: 2];
    assign port_bank[p*BSW +: BSW]  = mar_q[p*AW + 2 +: BSW];
    assign port_idx[p*IDXW +: IDXW] = mar_q[p*AW + 2 + BSW +: IDXW];
    assign ld_data[p*32 +: 32] = load_align(merged_arr[port_bank[p*BSW +: BSW]],
                                            port_off[p*2 +: 2], req_size[p*2 +: 2]);
  end

  xbar_bank_arb #(.NPORT(NPORT), .NBANK(NBANK)) u_arb (
    .clk(clk), .rst(rst), .req_valid(req_valid), .port_bank(port_bank),
    .grant(grant), .gnt_pb(gnt_pb), .stall(stall)
  );

  assign req_ready = !stall;
  assign ld_valid  = grant & ~req_store;

  // per-bank steering of the granted port
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_comb begin
      bank_re[b]                   = 1'b0;
      bank_raddr[b*IDXW +: IDXW]   = '0;
      st_fire[b]                   = 1'b0;
      st_idx[b*IDXW +: IDXW]       = '0;
      st_data[b*32 +: 32]          = '0;
      st_be[b*4 +: 4]              = '0;
      for (int p = 0; p < NPORT; p++) begin
        if (gnt_pb[b*NPORT + p]) begin
          bank_raddr[b*IDXW +: IDXW] = port_idx[p*IDXW +: IDXW];
          if (req_store[p]) begin
            st_fire[b]             = 1'b1;
            st_idx[b*IDXW +: IDXW] = port_idx[p*IDXW +: IDXW];
            st_data[b*32 +: 32]    = store_lanes(req_wdata[p*32 +: 32],
                                                 port_off[p*2 +: 2], req_size[p*2 +: 2]);
            st_be[b*4 +: 4]        = store_be(port_off[p*2 +: 2], req_size[p*2 +: 2]);
          end else begin
            bank_re[b] = 1'b1;
          end
        end
      end
    end
    assign merged_arr[b] = merged[b*32 +: 32];
  end

  xbar_store_buf #(.NBANK(NBANK), .IDXW(IDXW)) u_sbuf (
    .clk(clk), .rst(rst),
    .st_fire(st_fire), .st_idx(st_idx), .st_data(st_data), .st_be(st_be),
    .rd_idx(bank_raddr), .rd_data(bank_rdata), .merged(merged),
    .wb_en(bank_we), .wb_idx(bank_waddr), .wb_data(bank_wdata), .wb_be(bank_wbe)
  );
endmodule

// File: rtl/xbar_checks.sv
module xbar_checks #(
  parameter int NPORT = 4,
  parameter int NBANK = 8,
  parameter int AW    = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   stall,
  input logic [NPORT-1:0]       grant,
  input logic [NBANK*NPORT-1:0] gnt_pb,
  input logic [NPORT*AW-1:0]    mar_q,
  input logic [NPORT-1:0]       req_valid,
  input logic [NPORT-1:0]       req_store,
  input logic [NPORT-1:0]       ld_valid,
  input logic [NBANK-1:0]       bank_we
);
  // R4: a stalled cycle always serves someone
  a_r4_progress: assert property (@(posedge clk) disable iff (rst)
    stall |-> (grant != '0));

  // R6: address registers frozen across a stalled edge
  a_r6_mar_frozen: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(mar_q));

  // R9: a served store produces a bank write next cycle
  a_r9_write_follows: assert property (@(posedge clk) disable iff (rst)
    (|(grant & req_store)) |=> (|bank_we));

  // R11: load results only for requesting load ports
  a_r11_ld_needs_req: assert property (@(posedge clk) disable iff (rst)
    (|ld_valid) |-> ((ld_valid & ~(req_valid & ~req_store)) == '0));

  // R7: no request, no grant and no stall
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (req_valid == '0) |-> (!stall && grant == '0));

  // R5: at most one port per bank per cycle
  for (genvar b = 0; b < NBANK; b++) begin : g_b
    a_r5_one_per_bank: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt_pb[b*NPORT +: NPORT]));
  end
endmodule

bind mem_xbar4x8 xbar_checks #(.NPORT(NPORT), .NBANK(NBANK), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .grant(grant), .gnt_pb(gnt_pb),
  .mar_q(mar_q), .req_valid(req_valid), .req_store(req_store),
  .ld_valid(ld_valid), .bank_we(bank_we)
);

// File: tb/test_mem_xbar4x8.sv
module test_mem_xbar4x8;
  localparam int NP = 4, NB = 8, AW = 12, IW = 7, WPB = 128;

  logic clk = 1'b0, rst = 1'b1;
  logic [NP-1:0] mar_wr = '0;
  logic [NP*AW-1:0] mar_wdata = '0;
  logic [NP-1:0] req_valid = '0, req_store = '0;
  logic [NP*2-1:0] req_size = '0;
  logic [NP*32-1:0] req_wdata = '0;
  logic req_ready, stall;
  logic [NP-1:0] ld_valid;
  logic [NP*32-1:0] ld_data;
  logic [NB-1:0] bank_re, bank_we;
  logic [NB*IW-1:0] bank_raddr, bank_waddr;
  logic [NB*32-1:0] bank_rdata, bank_wdata;
  logic [NB*4-1:0] bank_wbe;

  mem_xbar4x8 i_mem_xbar4x8 (.*);

  always #4 clk = ~clk;

  logic [31:0] bmem [NB][WPB];
  logic [31:0] rmem [NB][WPB];
  always_comb
    for (int b = 0; b < NB; b++) bank_rdata[b*32 +: 32] = bmem[b][bank_raddr[b*IW +: IW]];
  always @(posedge clk)
    for (int b = 0; b < NB; b++)
      if (bank_we[b])
        for (int i = 0; i < 4; i++)
          if (bank_wbe[b*4+i]) bmem[b][bank_waddr[b*IW +: IW]][i*8 +: 8] <= bank_wdata[b*32+i*8 +: 8];

  int nchk = 0, nfail = 0, cyc = 0;
  string cur_tag = "R12";
  int ref_mar [NP];
  logic [NP-1:0] rdone = '0, served;
  logic exp_stall, last_stall;
  logic [NB-1:0] pw = '0;
  logic [IW-1:0] pidx [NB];
  logic [31:0] pdat [NB];
  logic [3:0] pbe [NB];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s (%s) %s act=%h exp=%h", tag, cur_tag, what, act, exp);
    end
  endtask

  function automatic int bank_of(int a); return (a >> 2) & 7; endfunction
  function automatic int idx_of(int a);  return (a >> 5) & 127; endfunction

  task automatic compare();
    logic [NP-1:0] rem;
    logic [NB-1:0] taken, ere;
    rem = req_valid & ~rdone; served = '0; taken = '0; ere = '0;
    for (int p = 0; p < NP; p++)
      if (rem[p] && !taken[bank_of(ref_mar[p])]) begin
        served[p] = 1'b1; taken[bank_of(ref_mar[p])] = 1'b1;
      end
    exp_stall = |(rem & ~served);
    chk("R4", "stall", stall, exp_stall);
    chk("R3", "req_ready", req_ready, !exp_stall);
    chk("R11", "ld_valid", ld_valid, served & ~req_store);
    for (int p = 0; p < NP; p++)
      if (served[p] && !req_store[p]) begin
        int a = ref_mar[p], off = ref_mar[p] & 3;
        logic [31:0] w, e;
        w = rmem[bank_of(a)][idx_of(a)];
        case (req_size[p*2 +: 2])
          2'd0: e = (w >> (8*off)) & 32'hff;
          2'd1: e = (w >> (16*(off/2))) & 32'hffff;
          default: e = w;
        endcase
        chk("R8", $sformatf("ld_data p%0d", p), ld_data[p*32 +: 32], e);
        ere[bank_of(a)] = 1'b1;
        chk("R2", $sformatf("bank_raddr b%0d", bank_of(a)), bank_raddr[bank_of(a)*IW +: IW], idx_of(a));
      end
    chk("R2", "bank_re", bank_re, ere);
    chk("R9", "bank_we", bank_we, pw);
    for (int b = 0; b < NB; b++)
      if (pw[b]) begin
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{pbe[b][i]}};
        chk("R9", "bank_waddr", bank_waddr[b*IW +: IW], pidx[b]);
        chk("R9", "bank_wbe", bank_wbe[b*4 +: 4], pbe[b]);
        chk("R9", "bank_wdata", bank_wdata[b*32 +: 32] & m, pdat[b] & m);
      end
    last_stall = exp_stall;
  endtask

  task automatic update();
    pw = '0;
    for (int p = 0; p < NP; p++)
      if (served[p] && req_store[p]) begin
        int a = ref_mar[p], off = ref_mar[p] & 3, eo, bk;
        logic [3:0] be;
        logic [31:0] d;
        bk = bank_of(a);
        case (req_size[p*2 +: 2])
          2'd0: begin eo = off;         be = 4'b0001 << off; end
          2'd1: begin eo = (off/2)*2;   be = 4'b0011 << eo;  end
          default: begin eo = 0;        be = 4'b1111;        end
        endcase
        d = req_wdata[p*32 +: 32] << (8*eo);
        for (int i = 0; i < 4; i++)
          if (be[i]) rmem[bk][idx_of(a)][i*8 +: 8] = d[i*8 +: 8];
        pw[bk] = 1'b1; pidx[bk] = IW'(idx_of(a)); pdat[bk] = d; pbe[bk] = be;
      end
    rdone = exp_stall ? (rdone | served) : '0;
    if (!exp_stall)
      for (int p = 0; p < NP; p++)
        if (mar_wr[p]) ref_mar[p] = int'(mar_wdata[p*AW +: AW]);
  endtask

  task automatic step();
    #3; compare(); @(posedge clk); update(); @(negedge clk);
  endtask

  function automatic logic [11:0] mk(int idx, int bk, int off);
    return 12'((idx << 5) | (bk << 2) | off);
  endfunction

  task automatic mars(logic [11:0] a0, a1, a2, a3);
    mar_wdata = {a3, a2, a1, a0}; mar_wr = 4'hF; req_valid = '0; step(); mar_wr = '0;
  endtask

  task automatic bundle(logic [3:0] v, logic [3:0] st, logic [7:0] sz, output int n);
    req_valid = v; req_store = st; req_size = sz;
    for (int p = 0; p < NP; p++) req_wdata[p*32 +: 32] = $urandom;
    n = 0;
    do begin step(); n++; end while (last_stall && n < 20);
    req_valid = '0; req_store = '0; mar_wr = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL R3 watchdog act=%0d exp<150000", cyc);
      summary(); $finish;
    end
  end

  initial begin
    int n;
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < WPB; w++) begin
        bmem[b][w] = 32'h5A00_0000 ^ (b << 20) ^ (w * 32'h9E37);
        rmem[b][w] = bmem[b][w];
      end
    for (int p = 0; p < NP; p++) ref_mar[p] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #3;
    chk("R12", "stall", stall, 0);
    chk("R12", "req_ready", req_ready, 1);
    chk("R12", "bank_we", bank_we, 0);
    @(negedge clk);
    // registers reset to zero: all ports hit bank 0 word 0
    bundle(4'hF, 4'h0, 8'hAA, n); chk("R12", "cycles", n, 4);

    cur_tag = "R3";
    mars(mk(0,0,0), mk(1,1,0), mk(2,2,0), mk(3,3,0));
    bundle(4'hF, 4'h0, 8'hAA, n); chk("R3", "cycles", n, 1);

    cur_tag = "R8";
    mars(mk(0,4,1), mk(0,5,2), mk(1,6,3), mk(2,7,3));
    bundle(4'hF, 4'h0, 8'b01_00_01_00, n); chk("R8", "cycles", n, 1);

    cur_tag = "R5";
    mars(mk(0,5,0), mk(1,5,0), mk(2,5,0), mk(3,5,0));
    bundle(4'hF, 4'h0, 8'hAA, n); chk("R4", "cycles", n, 4);

    cur_tag = "R6";
    mars(mk(0,2,0), mk(1,2,0), mk(4,6,0), mk(5,6,0));
    mar_wdata = {mk(3,3,0), mk(2,2,0), mk(1,1,0), mk(0,0,0)}; mar_wr = 4'hF;
    bundle(4'hF, 4'h0, 8'hAA, n); chk("R6", "cycles", n, 2);
    bundle(4'hF, 4'h0, 8'hAA, n); chk("R6", "cycles after", n, 1);

    cur_tag = "R1";
    mar_wdata = {mk(3,4,0), mk(2,4,0), mk(1,4,0), mk(0,4,0)}; mar_wr = 4'hF;
    bundle(4'hF, 4'h0, 8'hAA, n); chk("R1", "cycles old", n, 1);
    bundle(4'hF, 4'h0, 8'hAA, n); chk("R1", "cycles new", n, 4);

    cur_tag = "R7";
    mars(mk(0,3,0), mk(1,3,0), mk(2,3,0), mk(3,3,0));
    bundle(4'b0001, 4'h0, 8'hAA, n); chk("R7", "cycles one", n, 1);
    bundle(4'b1010, 4'h0, 8'hAA, n); chk("R7", "cycles two", n, 2);

    cur_tag = "R10";
    mars(mk(5,1,0), mk(5,1,2), mk(6,2,0), mk(6,2,1));
    bundle(4'b0001, 4'b0001, 8'hAA, n);
    bundle(4'b0010, 4'b0000, 8'b00_00_01_00, n);
    bundle(4'b1100, 4'b1100, 8'h00, n); chk("R10", "cycles", n, 2);
    bundle(4'b0100, 4'b0000, 8'hAA, n);

    cur_tag = "R11";
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 2) == 0)
        mars(mk($urandom_range(0,3), $urandom_range(0,7), $urandom_range(0,3)),
             mk($urandom_range(0,3), $urandom_range(0,7), $urandom_range(0,3)),
             mk($urandom_range(0,3), $urandom_range(0,7), $urandom_range(0,3)),
             mk($urandom_range(0,3), $urandom_range(0,7), $urandom_range(0,3)));
      if ($urandom_range(0, 3) == 0) begin
        for (int p = 0; p < NP; p++)
          mar_wdata[p*AW +: AW] = mk($urandom_range(0,3), $urandom_range(0,7), $urandom_range(0,3));
        mar_wr = 4'($urandom);
      end
      bundle(4'($urandom), 4'($urandom), 8'($urandom), n);
    end

    summary();
    $finish;
  end
endmodule